// File: doc/BRIEF.md
# Cache Miss Classification Monitor

This block observes a stream of memory accesses, one byte address per strobe, and models only the tag and recency state of a small set-associative cache with true least-recently-used replacement. For every access it reports, one clock later, whether the access hit. It also sorts every miss into one of three causes: first touch of a line (cold), a working set larger than the whole cache (capacity), or too many lines contending for one set (conflict).

To tell capacity from conflict, the block runs a shadow fully associative LRU tag store holding the same total number of lines. It also keeps a bounded log of every line address seen since reset. All three structures watch the same access stream and are updated on every access, hit or miss. The cache data, refill traffic, writes, coherence and address translation are not modelled. The block accepts an access on every cycle and never applies back-pressure, so the input is a plain strobe with no ready. Four saturating counters, one per result class, can be read at any time.

Top module: `miss_sorter`

## Requirements
- R1: The byte address splits into a line offset of log2(LINE_BYTES) low bits, a set index of log2(SETS) bits above it, and a tag made of all remaining upper bits, where SETS = TOTAL_BYTES / (LINE_BYTES * WAYS). Addresses differing only in offset bits refer to the same line.
- R2: An access hits when a valid way of the indexed set holds its tag; the result is then res_class = 2'b00 and res_hit = 1.
- R3: A miss fills the lowest-numbered invalid way of its set, or, if the set is full, replaces the least recently used way; every access, hit or fill, makes its way the most recently used.
- R4: A miss whose line address has never been accessed since reset is reported as res_class = 2'b01 (cold).
- R5: A miss on a previously seen line that the fully associative LRU shadow of SETS*WAYS lines also misses is reported as res_class = 2'b10 (capacity).
- R6: A miss on a previously seen line that the shadow would hit is reported as res_class = 2'b11 (conflict).
- R7: res_valid is high exactly in the cycle after a cycle with acc_valid high, and carries that access's result; cycles without acc_valid change no state.
- R8: The shadow store and the seen-line log are updated on every access, hits included, and back-to-back accesses each see the state left by the previous one.
- R9: Reset invalidates every entry of the tag array, the shadow and the seen-line log, and clears all counters and result outputs.
- R10: cnt_hit, cnt_cold, cnt_cap and cnt_conf each count accesses of their class, are updated in the same edge as the result, and hold at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access strobe, one access per high cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| res_valid | output | 1 | Result of the previous cycle's access is present |
| res_hit | output | 1 | The access hit the set-associative array |
| res_class | output | 2 | 00 hit, 01 cold, 10 capacity, 11 conflict |
| cnt_hit | output | CNT_W | Saturating count of hits |
| cnt_cold | output | CNT_W | Saturating count of cold misses |
| cnt_cap | output | CNT_W | Saturating count of capacity misses |
| cnt_conf | output | CNT_W | Saturating count of conflict misses |

## Verification
Two functions collide in one edge here. The fill of a missing line into a full set, with its eviction, coincides with a shadow hit that refreshes the same line's recency, and that pairing is exactly what yields a conflict. An install is also immediately followed, with no idle cycle, by a lookup of the line just installed or just evicted. The bench provokes both by issuing strided and alternating streams on consecutive cycles with a small geometry of four sets and two ways. It judges every result against a timestamp-based model of the array, the shadow and the seen log kept inside the bench.

// File: rtl/miss_sorter_pkg.sv
package miss_sorter_pkg;
  typedef enum logic [1:0] {
    CLS_HIT  = 2'b00,
    CLS_COLD = 2'b01,
    CLS_CAP  = 2'b10,
    CLS_CONF = 2'b11
  } miss_class_e;

  function automatic int clog2_min1(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/ms_lru_tags.sv
// Tag-only array with true LRU recency kept as per-way ages (0 = newest).
// With SETS = 1 it acts as a fully associative store.
module ms_lru_tags
  import miss_sorter_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int IDX_W = clog2_min1(SETS),
  localparam int ROWS  = 1 << IDX_W,
  localparam int WAY_W = clog2_min1(WAYS),
  localparam int AGE_W = clog2_min1(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  logic [TAG_W-1:0] tag_q [ROWS][WAYS];
  logic [WAYS-1:0]  vld_q [ROWS];
  logic [AGE_W-1:0] age_q [ROWS][WAYS];

  logic [WAYS-1:0]  hit_vec, inv_vec, old_vec;
  logic [WAY_W-1:0] sel_way;
  logic [AGE_W-1:0] sel_age;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
      inv_vec[w] = !vld_q[idx][w];
      old_vec[w] = (age_q[idx][w] == AGE_W'(WAYS - 1));
    end
  end

  assign hit = |hit_vec;

  // way touched by this access: matching way, else lowest invalid, else oldest
  always_comb begin
    sel_way = '0;
    if (hit) begin
      for (int w = WAYS - 1; w >= 0; w--) if (hit_vec[w]) sel_way = WAY_W'(w);
    end else if (|inv_vec) begin
      for (int w = WAYS - 1; w >= 0; w--) if (inv_vec[w]) sel_way = WAY_W'(w);
    end else begin
      for (int w = WAYS - 1; w >= 0; w--) if (old_vec[w]) sel_way = WAY_W'(w);
    end
    sel_age = age_q[idx][sel_way];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < ROWS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else if (upd) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == sel_way)         age_q[idx][w] <= '0;
        else if (age_q[idx][w] < sel_age) age_q[idx][w] <= age_q[idx][w] + 1'b1;
      end
      if (!hit) begin
        tag_q[idx][sel_way] <= tag;
        vld_q[idx][sel_way] <= 1'b1;
      end
    end
  end

  // a tag is never held twice in one set
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // ages stay a permutation, so a full set has exactly one oldest way
  assert_one_victim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !hit && (&vld_q[idx])) |-> ($countones(old_vec) == 1));

  // a filled line is found by the next lookup of the same row
  assert_fill_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !hit) |=> vld_q[$past(idx)][$past(sel_way)]);
endmodule

// File: rtl/ms_seen_log.sv
// Bounded log of line addresses accessed since reset.
module ms_seen_log
  import miss_sorter_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LINE_W = 26,
  localparam int PTR_W  = clog2_min1(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [LINE_W-1:0] line,
  output logic              found
);
  logic [LINE_W-1:0] ln_q [DEPTH];
  logic [FILL_W-1:0] fill_q;

  always_comb begin
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if ((FILL_W'(i) < fill_q) && (ln_q[i] == line)) found = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (upd && !found && (fill_q < FILL_W'(DEPTH))) begin
      ln_q[fill_q[PTR_W-1:0]] <= line;
      fill_q <= fill_q + 1'b1;
    end
  end

  assert_fill_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(DEPTH));

  assert_new_line_logged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !found && (fill_q < FILL_W'(DEPTH))) |=> (fill_q == $past(fill_q) + 1'b1));
endmodule

// File: rtl/miss_sorter.sv
module miss_sorter
  import miss_sorter_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int WAYS        = 4,
  parameter int TOTAL_BYTES = 16384,
  parameter int SEEN_DEPTH  = 256,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [1:0]        res_class,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_cold,
  output logic [CNT_W-1:0]  cnt_cap,
  output logic [CNT_W-1:0]  cnt_conf
);
  localparam int SETS   = TOTAL_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int LINES  = SETS * WAYS;

  logic [LINE_W-1:0] line_addr;
  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  set_tag;
  logic              unused_offset;

  assign line_addr     = acc_addr[ADDR_W-1:OFF_W];
  assign set_idx       = line_addr[IDX_W-1:0];
  assign set_tag       = line_addr[LINE_W-1:IDX_W];
  assign unused_offset = ^acc_addr[OFF_W-1:0];

  logic sa_hit, fa_hit, seen_hit;

  ms_lru_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_real (
    .clk(clk), .rst_n(rst_n), .upd(acc_valid),
    .idx(set_idx), .tag(set_tag), .hit(sa_hit)
  );

  ms_lru_tags #(.SETS(1), .WAYS(LINES), .TAG_W(LINE_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .upd(acc_valid),
    .idx(1'b0), .tag(line_addr), .hit(fa_hit)
  );

  ms_seen_log #(.DEPTH(SEEN_DEPTH), .LINE_W(LINE_W)) u_seen (
    .clk(clk), .rst_n(rst_n), .upd(acc_valid),
    .line(line_addr), .found(seen_hit)
  );

  miss_class_e cls_d;
  always_comb begin
    if (sa_hit)       cls_d = CLS_HIT;
    else if (!seen_hit) cls_d = CLS_COLD;
    else if (!fa_hit) cls_d = CLS_CAP;
    else              cls_d = CLS_CONF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_class <= 2'b00;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_hit   <= sa_hit;
        res_class <= cls_d;
      end
    end
  end

  logic [CNT_W-1:0] cnt_q [4];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) cnt_q[k] <= '0;
    end else if (acc_valid) begin
      for (int k = 0; k < 4; k++)
        if ((cls_d == miss_class_e'(k)) && (cnt_q[k] != '1)) cnt_q[k] <= cnt_q[k] + 1'b1;
    end
  end

  assign cnt_hit  = cnt_q[0];
  assign cnt_cold = cnt_q[1];
  assign cnt_cap  = cnt_q[2];
  assign cnt_conf = cnt_q[3];

  assert_result_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);

  assert_hit_flag_agrees_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_class == 2'b00)));

  assert_conflict_needs_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !sa_hit && fa_hit && seen_hit) |=> (res_class == 2'b11));

  assert_hit_count_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hit == '1) |=> (cnt_hit == '1));

  assert_conf_count_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_conf >= $past(cnt_conf)));
endmodule

// File: tb/miss_sorter_test.sv
`timescale 1ns/1ps
module miss_sorter_test;
  localparam int AW = 16, LB = 64, TW = 2, TOT = 512;
  localparam int TS = TOT / (LB * TW);   // 4 sets
  localparam int TFA = TS * TW;          // 8 shadow lines
  localparam int TSEEN = 64;
  localparam int CW = 5;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic res_valid, res_hit;
  logic [1:0] res_class;
  logic [CW-1:0] cnt_hit, cnt_cold, cnt_cap, cnt_conf;

  miss_sorter #(.ADDR_W(AW), .LINE_BYTES(LB), .WAYS(TW), .TOTAL_BYTES(TOT),
                .SEEN_DEPTH(TSEEN), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_class(res_class),
    .cnt_hit(cnt_hit), .cnt_cold(cnt_cold), .cnt_cap(cnt_cap), .cnt_conf(cnt_conf)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // reference model: last-use timestamps instead of ages
  int sa_ln [TS][TW]; bit sa_v [TS][TW]; int sa_ts [TS][TW];
  int fa_ln [TFA];    bit fa_v [TFA];    int fa_ts [TFA];
  int seen_ln [TSEEN]; int seen_n; int tnow;
  int exp_cnt [4];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < TS; s++) for (int w = 0; w < TW; w++) begin
      sa_v[s][w] = 0; sa_ts[s][w] = 0; sa_ln[s][w] = 0;
    end
    for (int i = 0; i < TFA; i++) begin fa_v[i] = 0; fa_ts[i] = 0; fa_ln[i] = 0; end
    seen_n = 0; tnow = 1;
    for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
  endtask

  task automatic model_step(input int line, output int cls);
    int s; bit sh; bit fh; bit seen; int sw; int fw; int best;
    s = line % TS; sh = 0; fh = 0; seen = 0; sw = -1; fw = -1;
    for (int w = 0; w < TW; w++) if (sa_v[s][w] && sa_ln[s][w] == line) begin sh = 1; sw = w; end
    for (int i = 0; i < TFA; i++) if (fa_v[i] && fa_ln[i] == line) begin fh = 1; fw = i; end
    for (int i = 0; i < seen_n; i++) if (seen_ln[i] == line) seen = 1;
    cls = sh ? 0 : (!seen ? 1 : (!fh ? 2 : 3));
    if (!sh) begin
      for (int w = TW - 1; w >= 0; w--) if (!sa_v[s][w]) sw = w;
      if (sw < 0) begin
        best = 0;
        for (int w = 1; w < TW; w++) if (sa_ts[s][w] < sa_ts[s][best]) best = w;
        sw = best;
      end
      sa_v[s][sw] = 1; sa_ln[s][sw] = line;
    end
    sa_ts[s][sw] = tnow;
    if (!fh) begin
      for (int i = TFA - 1; i >= 0; i--) if (!fa_v[i]) fw = i;
      if (fw < 0) begin
        best = 0;
        for (int i = 1; i < TFA; i++) if (fa_ts[i] < fa_ts[best]) best = i;
        fw = best;
      end
      fa_v[fw] = 1; fa_ln[fw] = line;
    end
    fa_ts[fw] = tnow;
    if (!seen && seen_n < TSEEN) begin seen_ln[seen_n] = line; seen_n++; end
    tnow++;
    if (exp_cnt[cls] < CMAX) exp_cnt[cls]++;
  endtask

  function automatic string cls_req(input int c);
    case (c)
      0: return "R2 hit";
      1: return "R4 cold";
      2: return "R5 capacity";
      default: return "R6 conflict";
    endcase
  endfunction

  // one access per cycle; result sampled just after the edge that registers it
  task automatic access(input int addr, input string tag);
    int ec;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = AW'(addr);
    model_step(addr / LB, ec);
    @(posedge clk); #1;
    check(res_valid === 1'b1, "R7 res_valid", int'(res_valid), 1);
    check(int'(res_class) == ec, cls_req(ec), int'(res_class), ec);
    check(res_hit === (ec == 0), tag, int'(res_hit), int'(ec == 0));
  endtask

  task automatic idle_and_counts(input string tag);
    logic [CW-1:0] h0;
    @(negedge clk); acc_valid = 1'b0; acc_addr = '1;
    h0 = cnt_hit;
    @(posedge clk); #1;
    check(res_valid === 1'b0, "R7 idle", int'(res_valid), 0);
    check(cnt_hit == h0, "R7 idle keeps counts", int'(cnt_hit), int'(h0));
    check(int'(cnt_hit)  == exp_cnt[0], {tag, " R10 cnt_hit"},  int'(cnt_hit),  exp_cnt[0]);
    check(int'(cnt_cold) == exp_cnt[1], {tag, " R10 cnt_cold"}, int'(cnt_cold), exp_cnt[1]);
    check(int'(cnt_cap)  == exp_cnt[2], {tag, " R10 cnt_cap"},  int'(cnt_cap),  exp_cnt[2]);
    check(int'(cnt_conf) == exp_cnt[3], {tag, " R10 cnt_conf"}, int'(cnt_conf), exp_cnt[3]);
  endtask

  task automatic do_reset();
    @(negedge clk); acc_valid = 1'b0; rst_n = 1'b0;
    model_clear();
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    #1;
    check(res_valid === 1'b0, "R9 res_valid after reset", int'(res_valid), 0);
    check((cnt_hit | cnt_cold | cnt_cap | cnt_conf) == '0, "R9 counters cleared",
          int'(cnt_hit | cnt_cold | cnt_cap | cnt_conf), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lfsr;
    do_reset();

    // sequential lines, twice: cold then capacity (R4, R5)
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 16; i++) access(i * LB, "R3 sequential");
    idle_and_counts("seq");

    // same line, different offsets: hits after the first (R1)
    do_reset();
    for (int i = 0; i < 8; i++) access((i % 2) * LB + i * 7, "R1 offset ignored");
    idle_and_counts("R1 hot pair");

    // set 0 contention: lines 0, 4, 8 with 2 ways; recency refresh (R3, R6, R8)
    do_reset();
    access(0 * LB, "R3 fill A");
    access(4 * LB, "R3 fill B");
    access(0 * LB, "R3 refresh A");
    access(8 * LB, "R3 evict B");
    access(0 * LB, "R3 A kept");
    access(4 * LB, "R6 B conflict");
    access(8 * LB, "R6 C conflict");
    idle_and_counts("R8 conflict");

    // reset clears seen log: previously seen line is cold again (R9)
    do_reset();
    access(0, "R9 first after reset");

    // stride sweep, each stride walked twice back to back (R8)
    for (int st = 1; st <= 8; st++) begin
      do_reset();
      for (int p = 0; p < 2; p++)
        for (int i = 0; i < 6; i++) access(i * st * LB + (i & 3), "R8 stride");
      idle_and_counts("R8 stride");
    end

    // pseudo-random stream over 32 lines
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 150; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0);
      access((lfsr & 31) * LB + (lfsr >> 11), "R3 random");
    end
    idle_and_counts("random");

    // saturation of the hit counter (R10)
    do_reset();
    for (int i = 0; i < 40; i++) access(3 * LB, "R10 repeat");
    idle_and_counts("R10 saturate");
    check(int'(cnt_hit) == CMAX, "R10 hit counter saturates", int'(cnt_hit), CMAX);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule